// File: doc/BRIEF.md
# Display PHY Power-Up Sequencer

This block brings a serial display PHY out of reset in one fixed order and then waits for the PHY's PLL to report lock. After a start request it holds the PHY in reset, shutdown and clock-off, pulses the test-clear line, and hands control to an external agent through a configure request/acknowledge pair. That agent programs the PLL and analog timing. The block then releases shutdown, then reset, loads the minimum stop time, enables the clock and loads the lane count. Finally it polls the synchronized lock input at a fixed interval, up to a bounded number of polls.

The outcome is reported as `done_o` (lock seen) or `timeout_o` (poll budget used up). From either end state a stop request runs the power-down order: reset low, shutdown asserted, then reset released high again. The block then returns to idle.

The state machine has these states:

- Power-up path: IDLE, RST_LO, SD_ON, CLK_OFF, TCLR_LO, TCLR_HI, TCLR_END, CFG, SD_OFF, RST_REL, STOP_LD, CLK_ON, LANE_LD, POLL.
- End states: UP and FAIL.
- Power-down path: DN_RST_LO, DN_SD_ON, DN_RST_HI.

The transitions are:

- IDLE goes to RST_LO on start.
- CFG waits for the configure acknowledge.
- POLL goes to UP when a poll sees lock, or to FAIL when the last poll does not.
- UP and FAIL go to DN_RST_LO on stop.
- DN_RST_HI returns to IDLE.
- Every other state advances to the next state in the list after one cycle.

Each state performs exactly one output action. That action is registered, so it appears on the pins one cycle after the state is entered.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset all PHY control outputs, `stop_time_o`, `lane_cnt_o`, `cfg_req_o`, `busy_o`, `done_o` and `timeout_o` are 0, and the block is idle.
- R2: A start request accepted in idle drives reset low, then shutdown low, then clock enable low, one step per cycle.
- R3: After the hold steps, test-clear is driven 0, then 1, then 0, on consecutive cycles, before `cfg_req_o` rises.
- R4: `cfg_req_o` stays high until `cfg_done_i` is seen. Shutdown is then released (output goes to 1), and in the next cycle reset is released.
- R5: One cycle after reset release, `stop_time_o` is loaded with STOP_TIME (default 0x1C).
- R6: One cycle after the stop time is loaded, the clock enable rises. In the next cycle `lane_cnt_o` is loaded with `lanes_i` minus one (`lanes_i` valid from 1 to 2^LANE_W).
- R7: The lock input passes through a two-flop synchronizer and is polled every POLL_INTERVAL cycles. With lock already stable, `done_o` rises POLL_INTERVAL cycles after `lane_cnt_o` is loaded.
- R8: If none of POLL_LIMIT polls sees lock, `timeout_o` rises POLL_INTERVAL*POLL_LIMIT cycles after the lane count load. `done_o` and `timeout_o` are never high together.
- R9: A stop request in the UP or FAIL state drives reset low, then shutdown low, then reset high on consecutive cycles, and returns to idle. Clock enable, stop time and lane count keep their values.
- R10: A start request is ignored unless the block is idle, and a stop request is ignored unless the block is in UP or FAIL. An ignored request changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Power-up request, acted on only in idle |
| stop_i | input | 1 | Power-down request, acted on only in UP or FAIL |
| lanes_i | input | LANE_W+1 | Number of active lanes, from 1 to 2^LANE_W |
| cfg_done_i | input | 1 | Acknowledge from the configuration agent |
| pll_lock_i | input | 1 | Asynchronous PLL lock status from the PHY |
| cfg_req_o | output | 1 | Request to the agent to program PLL and timing |
| phy_shutdown_n_o | output | 1 | PHY shutdown, active low |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| phy_clk_en_o | output | 1 | PHY clock enable |
| phy_test_clr_o | output | 1 | PHY test-clear |
| stop_time_o | output | STOP_W | Minimum stop time value |
| lane_cnt_o | output | LANE_W | Active lane count minus one |
| busy_o | output | 1 | Sequence in progress (not IDLE, UP or FAIL) |
| done_o | output | 1 | PLL locked, power-up complete |
| timeout_o | output | 1 | PLL lock not seen within the poll budget |

## Verification
Every PHY control action appears one cycle after its state is entered, so consecutive steps appear on consecutive cycles. The scoreboard records the cycle of each output change and compares the gap to the previous change against the expected gap: 1 for back-to-back steps, 2 where a step left the pins unchanged, and no gap check after a handshake wait. After the lane count load, `done_o` is due POLL_INTERVAL cycles later with lock stable, and `timeout_o` is due POLL_INTERVAL*POLL_LIMIT cycles later. The bench counts cycles at the falling edge from the load to the flag and compares the count exactly. Ignored requests are shown harmless because the monitor flags any output change that is not in its queue.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_RST_LO,
        S_SD_ON,
        S_CLK_OFF,
        S_TCLR_LO,
        S_TCLR_HI,
        S_TCLR_END,
        S_CFG,
        S_SD_OFF,
        S_RST_REL,
        S_STOP_LD,
        S_CLK_ON,
        S_LANE_LD,
        S_POLL,
        S_UP,
        S_FAIL,
        S_DN_RST_LO,
        S_DN_SD_ON,
        S_DN_RST_HI
    } seq_state_e;

    typedef struct packed {
        logic shutdown_n;
        logic rst_n;
        logic clk_en;
        logic test_clr;
    } phy_pins_t;

endpackage

// File: rtl/phy_lock_sync.sv
module phy_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
    parameter int INTERVAL = 64,
    parameter int LIMIT    = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o,
    output logic last_o
);
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int LW = $clog2(LIMIT + 1);

    logic [IW-1:0] ivl_q;
    logic [LW-1:0] polls_q;

    assign tick_o = run_i && (ivl_q == IW'(INTERVAL - 1));
    assign last_o = (polls_q == LW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q   <= '0;
            polls_q <= '0;
        end else if (!run_i) begin
            ivl_q   <= '0;
            polls_q <= '0;
        end else if (tick_o) begin
            ivl_q   <= '0;
            polls_q <= polls_q + 1'b1;
        end else begin
            ivl_q   <= ivl_q + 1'b1;
        end
    end
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
    import phy_seq_pkg::*;
#(
    parameter int          LANE_W        = 2,
    parameter int          STOP_W        = 8,
    parameter logic [7:0]  STOP_TIME     = 8'h1C,
    parameter int          POLL_INTERVAL = 64,
    parameter int          POLL_LIMIT    = 50000,
    parameter int          SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [LANE_W:0]   lanes_i,
    input  logic              cfg_done_i,
    input  logic              pll_lock_i,
    output logic              cfg_req_o,
    output logic              phy_shutdown_n_o,
    output logic              phy_rst_n_o,
    output logic              phy_clk_en_o,
    output logic              phy_test_clr_o,
    output logic [STOP_W-1:0] stop_time_o,
    output logic [LANE_W-1:0] lane_cnt_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);
    localparam logic [STOP_W-1:0] STOP_LOAD = STOP_W'(STOP_TIME);

    seq_state_e        state_q, state_d;
    phy_pins_t         pins_q;
    logic [STOP_W-1:0] stop_q;
    logic [LANE_W-1:0] lane_q;
    logic              lock_s;
    logic              poll_tick;
    logic              poll_last;

    phy_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pll_lock_i),
        .sync_o  (lock_s)
    );

    phy_poll_timer #(.INTERVAL(POLL_INTERVAL), .LIMIT(POLL_LIMIT)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == S_POLL),
        .tick_o (poll_tick),
        .last_o (poll_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start_i) state_d = S_RST_LO;
            S_RST_LO:    state_d = S_SD_ON;
            S_SD_ON:     state_d = S_CLK_OFF;
            S_CLK_OFF:   state_d = S_TCLR_LO;
            S_TCLR_LO:   state_d = S_TCLR_HI;
            S_TCLR_HI:   state_d = S_TCLR_END;
            S_TCLR_END:  state_d = S_CFG;
            S_CFG:       if (cfg_done_i) state_d = S_SD_OFF;
            S_SD_OFF:    state_d = S_RST_REL;
            S_RST_REL:   state_d = S_STOP_LD;
            S_STOP_LD:   state_d = S_CLK_ON;
            S_CLK_ON:    state_d = S_LANE_LD;
            S_LANE_LD:   state_d = S_POLL;
            S_POLL: begin
                if (poll_tick && lock_s)         state_d = S_UP;
                else if (poll_tick && poll_last) state_d = S_FAIL;
            end
            S_UP, S_FAIL: if (stop_i) state_d = S_DN_RST_LO;
            S_DN_RST_LO: state_d = S_DN_SD_ON;
            S_DN_SD_ON:  state_d = S_DN_RST_HI;
            S_DN_RST_HI: state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // registered output actions, one per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
            stop_q <= '0;
            lane_q <= '0;
        end else begin
            unique case (state_q)
                S_RST_LO, S_DN_RST_LO:  pins_q.rst_n      <= 1'b0;
                S_SD_ON, S_DN_SD_ON:    pins_q.shutdown_n <= 1'b0;
                S_CLK_OFF:              pins_q.clk_en     <= 1'b0;
                S_TCLR_LO, S_TCLR_END:  pins_q.test_clr   <= 1'b0;
                S_TCLR_HI:              pins_q.test_clr   <= 1'b1;
                S_SD_OFF:               pins_q.shutdown_n <= 1'b1;
                S_RST_REL, S_DN_RST_HI: pins_q.rst_n      <= 1'b1;
                S_STOP_LD:              stop_q            <= STOP_LOAD;
                S_CLK_ON:               pins_q.clk_en     <= 1'b1;
                S_LANE_LD:              lane_q            <= LANE_W'(lanes_i - 1'b1);
                default: ;
            endcase
        end
    end

    assign cfg_req_o        = (state_q == S_CFG);
    assign phy_shutdown_n_o = pins_q.shutdown_n;
    assign phy_rst_n_o      = pins_q.rst_n;
    assign phy_clk_en_o     = pins_q.clk_en;
    assign phy_test_clr_o   = pins_q.test_clr;
    assign stop_time_o      = stop_q;
    assign lane_cnt_o       = lane_q;
    assign busy_o           = (state_q != S_IDLE) && (state_q != S_UP) && (state_q != S_FAIL);
    assign done_o           = (state_q == S_UP);
    assign timeout_o        = (state_q == S_FAIL);
endmodule

// File: rtl/phy_seq_checker.sv
module phy_seq_checker #(
    parameter int         STOP_W    = 8,
    parameter logic [7:0] STOP_TIME = 8'h1C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_done_i,
    input logic              cfg_req_o,
    input logic              phy_shutdown_n_o,
    input logic              phy_rst_n_o,
    input logic              phy_clk_en_o,
    input logic              phy_test_clr_o,
    input logic [STOP_W-1:0] stop_time_o,
    input logic              done_o,
    input logic              timeout_o
);
    p_tclr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_test_clr_o) |-> !phy_shutdown_n_o && !phy_rst_n_o && !phy_clk_en_o);

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_o && !cfg_done_i) |=> cfg_req_o);

    p_sd_before_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_shutdown_n_o) |-> !phy_rst_n_o);

    p_clk_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_clk_en_o) |-> phy_rst_n_o && phy_shutdown_n_o
                                && (stop_time_o == STOP_W'(STOP_TIME)));

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> phy_clk_en_o && phy_rst_n_o && phy_shutdown_n_o);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    p_cfg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_o |-> !phy_test_clr_o && !phy_shutdown_n_o);
endmodule

bind phy_pwrup_seq phy_seq_checker #(.STOP_W(STOP_W), .STOP_TIME(STOP_TIME)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_done_i       (cfg_done_i),
    .cfg_req_o        (cfg_req_o),
    .phy_shutdown_n_o (phy_shutdown_n_o),
    .phy_rst_n_o      (phy_rst_n_o),
    .phy_clk_en_o     (phy_clk_en_o),
    .phy_test_clr_o   (phy_test_clr_o),
    .stop_time_o      (stop_time_o),
    .done_o           (done_o),
    .timeout_o        (timeout_o)
);

// File: tb/test_phy_pwrup_seq.sv
module test_phy_pwrup_seq;
    localparam int IVL = 3;
    localparam int LIM = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, cfg_done_i = 1'b0, pll_lock_i = 1'b0;
    logic [2:0] lanes_i = 3'd4;
    logic       cfg_req_o, sd_n, prst_n, clk_en, tclr, busy_o, done_o, timeout_o;
    logic [7:0] stop_t;
    logic [1:0] lane_c;

    int n_chk = 0, n_fail = 0, cyc = 0, last_chg = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    typedef struct { logic [13:0] vec; int gap; string tag; } exp_t;
    exp_t exp_q[$];
    logic [13:0] prev_v;

    always #10 clk = ~clk;

    phy_pwrup_seq #(.POLL_INTERVAL(IVL), .POLL_LIMIT(LIM)) i_phy_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .lanes_i(lanes_i), .cfg_done_i(cfg_done_i), .pll_lock_i(pll_lock_i),
        .cfg_req_o(cfg_req_o), .phy_shutdown_n_o(sd_n), .phy_rst_n_o(prst_n),
        .phy_clk_en_o(clk_en), .phy_test_clr_o(tclr), .stop_time_o(stop_t),
        .lane_cnt_o(lane_c), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    function automatic logic [13:0] mk(logic s, logic r, logic c, logic t,
                                       logic [7:0] st, logic [1:0] ln);
        return {s, r, c, t, st, ln};
    endfunction

    wire [13:0] cur_v = {sd_n, prst_n, clk_en, tclr, stop_t, lane_c};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [13:0] v, input int gap, input string tag);
        exp_t e;
        e.vec = v; e.gap = gap; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: compare every output change against the expected queue
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_en && cur_v !== prev_v) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected output change", int'(cur_v), int'(prev_v));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cur_v === e.vec, {e.tag, " value"}, int'(cur_v), int'(e.vec));
                if (e.gap != 0)
                    chk((cyc - last_chg) == e.gap, {e.tag, " cycle gap"}, cyc - last_chg, e.gap);
            end
            last_chg <= cyc;
        end
        prev_v <= cur_v;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic wait_cfg_then_ack(input bit poke);
        while (!cfg_req_o) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(cfg_req_o === 1'b1, "R4 cfg_req held while waiting", cfg_req_o, 1);
        if (poke) begin
            start_i = 1'b1; stop_i = 1'b1;
            @(negedge clk) start_i = 1'b0; stop_i = 1'b0;
            repeat (2) @(negedge clk);
            chk(cfg_req_o === 1'b1 && busy_o === 1'b1, "R10 requests ignored while busy",
                cfg_req_o, 1);
        end
        cfg_done_i = 1'b1;
        @(negedge clk) cfg_done_i = 1'b0;
    endtask

    task automatic cycles_to(input bit want_done, output int n);
        n = 0;
        while (!(want_done ? done_o : timeout_o) && n < 100) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        int n;
        lanes_i = 3'd4;
        pll_lock_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cur_v === 14'd0, "R1 control outputs after reset", int'(cur_v), 0);
        chk({cfg_req_o, busy_o, done_o, timeout_o} === 4'b0, "R1 status after reset",
            int'({cfg_req_o, busy_o, done_o, timeout_o}), 0);
        prev_v = cur_v;
        mon_en = 1'b1;

        // ---- power-up 1: lanes 4, lock stable ----
        push(mk(0,0,0,1,8'h00,2'd0), 0, "R3 test-clear high");
        push(mk(0,0,0,0,8'h00,2'd0), 1, "R3 test-clear low");
        push(mk(1,0,0,0,8'h00,2'd0), 0, "R4 shutdown released");
        push(mk(1,1,0,0,8'h00,2'd0), 1, "R4 reset released");
        push(mk(1,1,0,0,8'h1C,2'd0), 1, "R5 stop time");
        push(mk(1,1,1,0,8'h1C,2'd0), 1, "R6 clock enable");
        push(mk(1,1,1,0,8'h1C,2'd3), 1, "R6 lane count 4");
        pulse_start();
        wait_cfg_then_ack(1'b1);
        while (lane_c !== 2'd3) @(negedge clk);
        cycles_to(1'b1, n);
        chk(n == IVL, "R7 done delay after lane load", n, IVL);
        chk(timeout_o === 1'b0, "R8 no timeout when locked", timeout_o, 0);
        chk(exp_q.size() == 0, "R2 power-up sequence complete", exp_q.size(), 0);

        // start while UP is ignored
        pulse_start();
        repeat (4) @(negedge clk);
        chk(done_o === 1'b1 && busy_o === 1'b0, "R10 start ignored in UP", done_o, 1);

        // ---- power-down from UP ----
        push(mk(1,0,1,0,8'h1C,2'd3), 0, "R9 reset low");
        push(mk(0,0,1,0,8'h1C,2'd3), 1, "R9 shutdown asserted");
        push(mk(0,1,1,0,8'h1C,2'd3), 1, "R9 reset high");
        pulse_stop();
        repeat (5) @(negedge clk);
        chk({busy_o, done_o, timeout_o} === 3'b0, "R9 back to idle",
            int'({busy_o, done_o, timeout_o}), 0);

        // stop in idle is ignored
        pulse_stop();
        repeat (4) @(negedge clk);
        chk(busy_o === 1'b0, "R10 stop ignored in idle", busy_o, 0);

        // ---- power-up 2: lanes 2, no lock -> timeout ----
        pll_lock_i = 1'b0;
        lanes_i = 3'd2;
        push(mk(0,0,1,0,8'h1C,2'd3), 0, "R2 reset low");
        push(mk(0,0,0,0,8'h1C,2'd3), 2, "R2 clock off after shutdown step");
        push(mk(0,0,0,1,8'h1C,2'd3), 2, "R3 test-clear high");
        push(mk(0,0,0,0,8'h1C,2'd3), 1, "R3 test-clear low");
        push(mk(1,0,0,0,8'h1C,2'd3), 0, "R4 shutdown released");
        push(mk(1,1,0,0,8'h1C,2'd3), 1, "R4 reset released");
        push(mk(1,1,1,0,8'h1C,2'd3), 2, "R6 clock enable");
        push(mk(1,1,1,0,8'h1C,2'd1), 1, "R6 lane count 2");
        pulse_start();
        wait_cfg_then_ack(1'b0);
        while (lane_c !== 2'd1) @(negedge clk);
        cycles_to(1'b0, n);
        chk(n == IVL * LIM, "R8 timeout delay", n, IVL * LIM);
        chk(done_o === 1'b0, "R8 done low on timeout", done_o, 0);
        chk(exp_q.size() == 0, "R2 second sequence complete", exp_q.size(), 0);

        // ---- power-down from FAIL ----
        push(mk(1,0,1,0,8'h1C,2'd1), 0, "R9 reset low");
        push(mk(0,0,1,0,8'h1C,2'd1), 1, "R9 shutdown asserted");
        push(mk(0,1,1,0,8'h1C,2'd1), 1, "R9 reset high");
        pulse_stop();
        repeat (5) @(negedge clk);
        chk(timeout_o === 1'b0 && busy_o === 1'b0, "R9 timeout cleared", timeout_o, 0);

        // ---- power-up 3: lanes 1, lock arrives during polling ----
        lanes_i = 3'd1;
        push(mk(0,0,1,0,8'h1C,2'd1), 0, "R2 reset low");
        push(mk(0,0,0,0,8'h1C,2'd1), 2, "R2 clock off");
        push(mk(0,0,0,1,8'h1C,2'd1), 2, "R3 test-clear high");
        push(mk(0,0,0,0,8'h1C,2'd1), 1, "R3 test-clear low");
        push(mk(1,0,0,0,8'h1C,2'd1), 0, "R4 shutdown released");
        push(mk(1,1,0,0,8'h1C,2'd1), 1, "R4 reset released");
        push(mk(1,1,1,0,8'h1C,2'd1), 2, "R6 clock enable");
        push(mk(1,1,1,0,8'h1C,2'd0), 1, "R6 lane count 1");
        pulse_start();
        wait_cfg_then_ack(1'b0);
        while (lane_c !== 2'd0) @(negedge clk);
        repeat (7) @(negedge clk);
        chk(done_o === 1'b0 && timeout_o === 1'b0, "R7 still polling", done_o, 0);
        pll_lock_i = 1'b1;
        cycles_to(1'b1, n);
        chk(done_o === 1'b1, "R7 late lock reaches done", done_o, 1);
        chk(timeout_o === 1'b0, "R8 no timeout after late lock", timeout_o, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected changes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule